// File: doc/BRIEF.md
# Read Burst Splitter

This block sits between a producer of large read requests and the read-address channel of an AXI4 master port. The producer hands over one request, made of a start address, a total beat count and a beat size code. The block turns it into a run of incrementing sub-bursts on the downstream command channel. No sub-burst is longer than a configured cap, and none reaches past a 4096-byte address page. The address advances by the bytes each sub-burst covered.

The block counts sub-bursts that have been issued but whose final data beat has not yet come back. While that count sits at a configured ceiling, it holds off the next sub-burst. It watches the read-data channel for a handshake on the beat marked as last. Otherwise that channel goes straight through: data, response and last marker flow upstream unchanged, and the upstream ready flows back down. The reset input is active low and takes effect at once. Its release is synchronised to the clock inside the block.

Top module: `rsplit_top`

## Requirements
- R1: While reset is asserted, and for the few cycles of its synchronised release, `req_ready` is low. Once the block is idle after reset, `req_ready` is high.
- R2: Each sub-burst carries `dn_cmd_len` = beats - 1. Its beat count is the smallest of three values: the beats still owed on the request, `MAX_BURST`, and (4096 - (address mod 4096)) >> size.
- R3: For every issued command, (address mod 4096) + (`dn_cmd_len` + 1) << `dn_cmd_size` is at most 4096.
- R4: No command has `dn_cmd_len` + 1 greater than `MAX_BURST`.
- R5: The first sub-burst starts at the request address. Each later one starts where the previous one ended, at the previous address plus beats << size. `dn_cmd_size` equals the request's size code, and the beats of all sub-bursts add up to the request's total.
- R6: While `dn_cmd_valid` is high and `dn_cmd_ready` is low, the next cycle keeps `dn_cmd_valid` high with `dn_cmd_addr`, `dn_cmd_len` and `dn_cmd_size` unchanged.
- R7: While a request has beats left to issue, `dn_cmd_valid` is high exactly when the outstanding sub-burst count is below `MAX_OUTST`. With no beats left to issue it is low.
- R8: The outstanding count rises by one on each command handshake and falls by one on each read-data handshake with `dn_dat_last` high. Both in the same cycle leave it unchanged.
- R9: `req_ready` is high only when no beats remain to be issued. A new request is therefore taken only after the last command of the previous one has completed its handshake.
- R10: `up_dat_valid`, `up_dat_data`, `up_dat_resp` and `up_dat_last` equal their `dn_dat_*` counterparts in the same cycle, and `dn_dat_ready` equals `up_dat_ready`.
- R11: Asserting `rst_n` low drives `dn_cmd_valid` low at once, without waiting for a clock edge, and it stays low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Start byte address, aligned to the beat size |
| req_beats | input | CNT_W | Total beats requested, at least 1 |
| req_size | input | 3 | Beat size code, bytes = 1 << code |
| dn_cmd_valid | output | 1 | Sub-burst command valid |
| dn_cmd_ready | input | 1 | Command accepted downstream |
| dn_cmd_addr | output | ADDR_W | Sub-burst start address |
| dn_cmd_len | output | 8 | Sub-burst beats minus one |
| dn_cmd_size | output | 3 | Beat size code of the sub-burst |
| dn_dat_valid | input | 1 | Read beat valid from downstream |
| dn_dat_ready | output | 1 | Read beat accepted (copy of upstream ready) |
| dn_dat_data | input | DATA_W | Read beat data |
| dn_dat_resp | input | 2 | Read beat response code |
| dn_dat_last | input | 1 | Final beat of a sub-burst |
| up_dat_valid | output | 1 | Read beat valid toward requester |
| up_dat_ready | input | 1 | Requester accepts the beat |
| up_dat_data | output | DATA_W | Read beat data toward requester |
| up_dat_resp | output | 2 | Response code toward requester |
| up_dat_last | output | 1 | Last marker toward requester |

## Verification
The properties assume well-formed inputs. A request asks for at least one beat, its address is aligned to its beat size, and its size code fits the data bus. Downstream returns exactly one last-marked beat for each command it accepted, and never more last beats than there are outstanding sub-bursts. The bench's downstream model queues each accepted command's length and answers with precisely that many beats, marking only the final one. The request sweep builds every address as a page edge minus a whole number of beats, so alignment holds by construction. Upstream ready and downstream valid are driven from a pseudo-random sequence so that the outstanding ceiling is reached, and so that commands and final beats coincide.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;

  // Address page that no sub-burst may straddle
  localparam int unsigned PAGE_SH    = 12;
  localparam int unsigned PAGE_BYTES = 1 << PAGE_SH;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/rsplit_rst_sync.sv
module rsplit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_core_n = sync_q[1];

endmodule

// File: rtl/rsplit_len_calc.sv
module rsplit_len_calc
  import rsplit_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MAX_BURST = 16
) (
  input  logic [PAGE_SH-1:0] page_off,
  input  logic [CNT_W-1:0]   rem_beats,
  input  logic [2:0]         beat_size,
  output logic [8:0]         burst_beats,
  output logic [7:0]         burst_len
);

  localparam int unsigned MW = (CNT_W > PAGE_SH + 1) ? CNT_W : PAGE_SH + 1;

  logic [MW-1:0] room_bytes;
  logic [MW-1:0] room_beats;
  logic [MW-1:0] rem_ext;
  logic [MW-1:0] cap_ext;
  logic [MW-1:0] pick_rc;
  logic [MW-1:0] pick_all;

  always_comb begin
    room_bytes = MW'(PAGE_BYTES) - MW'(page_off);
    room_beats = room_bytes >> beat_size;
    rem_ext    = MW'(rem_beats);
    cap_ext    = MW'(MAX_BURST);
    pick_rc    = (rem_ext < cap_ext) ? rem_ext : cap_ext;
    pick_all   = (pick_rc < room_beats) ? pick_rc : room_beats;
  end

  assign burst_beats = 9'(pick_all);
  assign burst_len   = 8'(pick_all - MW'(1));

endmodule

// File: rtl/rsplit_outst.sv
module rsplit_outst #(
  parameter int unsigned MAX_OUTST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_inc,
  input  logic cnt_dec,
  output logic may_issue
);

  localparam int unsigned CW = $clog2(MAX_OUTST + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Simultaneous increment and decrement cancel: no register write at all
  assign cnt_en = cnt_inc ^ cnt_dec;

  always_comb begin
    if (cnt_inc) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign may_issue = (cnt_q != CW'(MAX_OUTST));

endmodule

// File: rtl/rsplit_issue.sv
module rsplit_issue
  import rsplit_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MAX_BURST = 16
) (
  input  logic              clk,
  input  logic              rst_core_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_beats,
  input  logic [2:0]        req_size,
  input  logic              may_issue,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_len,
  output logic [2:0]        cmd_size,
  output logic              cmd_fire
);

  seq_state_e        seq_q, seq_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [2:0]        size_q, size_d;

  logic [8:0]        sub_beats;
  logic [7:0]        sub_len;
  logic              take_req;
  logic              fire_w;
  logic              last_sub;
  logic              upd_en;
  logic [ADDR_W-1:0] step_bytes;

  rsplit_len_calc #(
    .CNT_W     (CNT_W),
    .MAX_BURST (MAX_BURST)
  ) len_i (
    .page_off    (addr_q[PAGE_SH-1:0]),
    .rem_beats   (rem_q),
    .beat_size   (size_q),
    .burst_beats (sub_beats),
    .burst_len   (sub_len)
  );

  assign req_ready  = (seq_q == SEQ_IDLE) && rst_core_n;
  assign cmd_valid  = (seq_q == SEQ_RUN) && may_issue;
  assign cmd_addr   = addr_q;
  assign cmd_len    = sub_len;
  assign cmd_size   = size_q;
  assign fire_w     = cmd_valid && cmd_ready;
  assign cmd_fire   = fire_w;
  assign take_req   = req_valid && req_ready;
  assign last_sub   = (rem_q == CNT_W'(sub_beats));
  assign step_bytes = ADDR_W'(sub_beats) << size_q;
  assign upd_en     = take_req || fire_w;

  always_comb begin
    seq_d  = seq_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    size_d = size_q;
    if (take_req) begin
      seq_d  = SEQ_RUN;
      addr_d = req_addr;
      rem_d  = req_beats;
      size_d = req_size;
    end else if (fire_w) begin
      addr_d = addr_q + step_bytes;
      rem_d  = rem_q - CNT_W'(sub_beats);
      if (last_sub) begin
        seq_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      seq_q  <= SEQ_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      size_q <= '0;
    end else if (upd_en) begin
      seq_q  <= seq_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      size_q <= size_d;
    end
  end

endmodule

// File: rtl/rsplit_top.sv
module rsplit_top #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MAX_BURST = 16,
  parameter int unsigned MAX_OUTST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_beats,
  input  logic [2:0]        req_size,
  output logic              dn_cmd_valid,
  input  logic              dn_cmd_ready,
  output logic [ADDR_W-1:0] dn_cmd_addr,
  output logic [7:0]        dn_cmd_len,
  output logic [2:0]        dn_cmd_size,
  input  logic              dn_dat_valid,
  output logic              dn_dat_ready,
  input  logic [DATA_W-1:0] dn_dat_data,
  input  logic [1:0]        dn_dat_resp,
  input  logic              dn_dat_last,
  output logic              up_dat_valid,
  input  logic              up_dat_ready,
  output logic [DATA_W-1:0] up_dat_data,
  output logic [1:0]        up_dat_resp,
  output logic              up_dat_last
);

  logic rst_core_n;
  logic may_issue;
  logic cmd_fire;
  logic burst_done;

  rsplit_rst_sync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  rsplit_issue #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .MAX_BURST (MAX_BURST)
  ) issue_i (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_beats  (req_beats),
    .req_size   (req_size),
    .may_issue  (may_issue),
    .cmd_valid  (dn_cmd_valid),
    .cmd_ready  (dn_cmd_ready),
    .cmd_addr   (dn_cmd_addr),
    .cmd_len    (dn_cmd_len),
    .cmd_size   (dn_cmd_size),
    .cmd_fire   (cmd_fire)
  );

  assign burst_done = dn_dat_valid && up_dat_ready && dn_dat_last;

  rsplit_outst #(
    .MAX_OUTST (MAX_OUTST)
  ) outst_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cnt_inc   (cmd_fire),
    .cnt_dec   (burst_done),
    .may_issue (may_issue)
  );

  // Read data path: straight wires in both directions
  assign up_dat_valid = dn_dat_valid;
  assign up_dat_data  = dn_dat_data;
  assign up_dat_resp  = dn_dat_resp;
  assign up_dat_last  = dn_dat_last;
  assign dn_dat_ready = up_dat_ready;

endmodule

// File: rtl/rsplit_chk.sv
module rsplit_chk
  import rsplit_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MAX_BURST = 16,
  parameter int unsigned MAX_OUTST = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              dn_cmd_valid,
  input logic              dn_cmd_ready,
  input logic [ADDR_W-1:0] dn_cmd_addr,
  input logic [7:0]        dn_cmd_len,
  input logic [2:0]        dn_cmd_size,
  input logic              dn_dat_valid,
  input logic              dn_dat_ready,
  input logic              dn_dat_last
);

  localparam int unsigned CW = $clog2(MAX_OUTST + 1) + 1;

  logic [CW-1:0] seen_q;
  logic          cmd_hs;
  logic          end_hs;

  assign cmd_hs = dn_cmd_valid && dn_cmd_ready;
  assign end_hs = dn_dat_valid && dn_dat_ready && dn_dat_last;

  // Independent count of open sub-bursts, rebuilt from port handshakes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (cmd_hs && !end_hs) begin
      seen_q <= seen_q + CW'(1);
    end else if (end_hs && !cmd_hs) begin
      seen_q <= seen_q - CW'(1);
    end
  end

  AST_RST_CMD_LOW: assert property (@(posedge clk) !rst_n |-> !dn_cmd_valid); // R11

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_cmd_valid && !dn_cmd_ready |=> dn_cmd_valid && $stable(dn_cmd_addr)
      && $stable(dn_cmd_len) && $stable(dn_cmd_size)); // R6

  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    dn_cmd_valid |-> (32'(dn_cmd_addr[PAGE_SH-1:0])
      + ((32'(dn_cmd_len) + 32'd1) << dn_cmd_size)) <= 32'(PAGE_BYTES)); // R3

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    dn_cmd_valid |-> (32'(dn_cmd_len) + 32'd1) <= 32'(MAX_BURST)); // R4

  AST_OPEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    dn_cmd_valid |-> seen_q < CW'(MAX_OUTST)); // R7

  AST_OPEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= CW'(MAX_OUTST)); // R8

  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !dn_cmd_valid); // R9

endmodule

bind rsplit_top rsplit_chk #(
  .ADDR_W    (ADDR_W),
  .MAX_BURST (MAX_BURST),
  .MAX_OUTST (MAX_OUTST)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .dn_cmd_valid (dn_cmd_valid),
  .dn_cmd_ready (dn_cmd_ready),
  .dn_cmd_addr  (dn_cmd_addr),
  .dn_cmd_len   (dn_cmd_len),
  .dn_cmd_size  (dn_cmd_size),
  .dn_dat_valid (dn_dat_valid),
  .dn_dat_ready (dn_dat_ready),
  .dn_dat_last  (dn_dat_last)
);

// File: tb/rsplit_top_tb_top.sv
`timescale 1ns/1ps
module rsplit_top_tb_top;

  localparam int AW   = 16;
  localparam int DW   = 32;
  localparam int CW   = 8;
  localparam int MAXB = 4;
  localparam int MAXO = 2;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] req_beats;
  logic [2:0]    req_size;
  logic          dn_cmd_valid;
  logic          dn_cmd_ready;
  logic [AW-1:0] dn_cmd_addr;
  logic [7:0]    dn_cmd_len;
  logic [2:0]    dn_cmd_size;
  logic          dn_dat_valid;
  logic          dn_dat_ready;
  logic [DW-1:0] dn_dat_data;
  logic [1:0]    dn_dat_resp;
  logic          dn_dat_last;
  logic          up_dat_valid;
  logic          up_dat_ready;
  logic [DW-1:0] up_dat_data;
  logic [1:0]    up_dat_resp;
  logic          up_dat_last;

  rsplit_top #(
    .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .MAX_BURST(MAXB), .MAX_OUTST(MAXO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_beats(req_beats), .req_size(req_size),
    .dn_cmd_valid(dn_cmd_valid), .dn_cmd_ready(dn_cmd_ready),
    .dn_cmd_addr(dn_cmd_addr), .dn_cmd_len(dn_cmd_len), .dn_cmd_size(dn_cmd_size),
    .dn_dat_valid(dn_dat_valid), .dn_dat_ready(dn_dat_ready),
    .dn_dat_data(dn_dat_data), .dn_dat_resp(dn_dat_resp), .dn_dat_last(dn_dat_last),
    .up_dat_valid(up_dat_valid), .up_dat_ready(up_dat_ready),
    .up_dat_data(up_dat_data), .up_dat_resp(up_dat_resp), .up_dat_last(up_dat_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int exp_rem = 0;
  int exp_addr = 0;
  int exp_size = 0;
  int outst = 0;
  int fifo_len [8];
  int fhead = 0, ftail = 0, fcnt = 0;
  int rbeat = 0;
  int dcnt = 0;
  int mode = 0;
  bit want_req = 0, req_pend = 0, accepted = 0;
  bit prev_stall = 0;
  int hold_addr = 0, hold_len = 0, hold_size = 0;
  int want_addr = 0, want_beats = 0, want_size = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len_f(input int a, input int rem, input int s);
    int room;
    int m;
    room = (4096 - (a % 4096)) >> s;
    m = rem;
    if (MAXB < m) m = MAXB;
    if (room < m) m = room;
    return m;
  endfunction

  // One clock: drive at the falling edge, check, and log what completes at the next rise
  task automatic tick();
    int el;
    @(negedge clk);
    if (req_pend) begin
      req_valid = 1'b0;
      req_pend = 0;
    end
    if (want_req && !req_valid) begin
      req_valid = 1'b1;
      req_addr  = AW'(want_addr);
      req_beats = CW'(want_beats);
      req_size  = 3'(want_size);
    end
    dn_cmd_ready = (mode == 2) ? 1'b0 : ((mode == 0) ? 1'b1 : lfsr[0]);
    up_dat_ready = (mode == 1) ? lfsr[2] : 1'b1;
    dn_dat_valid = (mode != 2) && (fcnt > 0) && lfsr[1];
    dn_dat_data  = 32'hC0DE0000 + DW'(dcnt);
    dn_dat_resp  = 2'(dcnt);
    dn_dat_last  = (fcnt > 0) && (rbeat == fifo_len[fhead] - 1);
    #1;
    // R7: issue exactly when work remains and the open count is below the ceiling
    if (exp_rem > 0) begin
      chk(dn_cmd_valid == (outst < MAXO), "R7 cmd_valid vs open count",
          int'(dn_cmd_valid), int'(outst < MAXO));
      chk(!req_ready, "R9 req_ready while beats remain", int'(req_ready), 0);
    end else begin
      chk(!dn_cmd_valid, "R7 cmd_valid with nothing left", int'(dn_cmd_valid), 0);
    end
    // R6: a stalled command is held unchanged
    if (prev_stall) begin
      chk(dn_cmd_valid && int'(dn_cmd_addr) == hold_addr && int'(dn_cmd_len) == hold_len
          && int'(dn_cmd_size) == hold_size, "R6 held command addr",
          int'(dn_cmd_addr), hold_addr);
    end
    // R10: read path passthrough
    chk(up_dat_valid == dn_dat_valid && dn_dat_ready == up_dat_ready
        && (!dn_dat_valid || (up_dat_data == dn_dat_data && up_dat_resp == dn_dat_resp
        && up_dat_last == dn_dat_last)), "R10 read passthrough data",
        int'(up_dat_data), int'(dn_dat_data));
    // Command handshake at the coming rise
    prev_stall = dn_cmd_valid && !dn_cmd_ready;
    hold_addr = int'(dn_cmd_addr);
    hold_len  = int'(dn_cmd_len);
    hold_size = int'(dn_cmd_size);
    if (dn_cmd_valid && dn_cmd_ready) begin
      el = exp_len_f(exp_addr, exp_rem, exp_size);
      chk(int'(dn_cmd_addr) == exp_addr, "R5 sub-burst address", int'(dn_cmd_addr), exp_addr);
      chk(int'(dn_cmd_size) == exp_size, "R5 sub-burst size", int'(dn_cmd_size), exp_size);
      chk(int'(dn_cmd_len) + 1 == el, "R2 sub-burst length", int'(dn_cmd_len) + 1, el);
      chk(((int'(dn_cmd_addr) % 4096) + ((int'(dn_cmd_len) + 1) << int'(dn_cmd_size))) <= 4096,
          "R3 page crossing", int'(dn_cmd_addr), exp_addr);
      chk(int'(dn_cmd_len) + 1 <= MAXB, "R4 length cap", int'(dn_cmd_len) + 1, MAXB);
      exp_addr = exp_addr + (el << exp_size);
      exp_rem  = exp_rem - el;
      fifo_len[ftail] = el;
      ftail = (ftail + 1) % 8;
      fcnt++;
      outst++;
    end
    // Read-data handshake at the coming rise (R8 bookkeeping)
    if (dn_dat_valid && up_dat_ready) begin
      dcnt++;
      if (dn_dat_last) begin
        fhead = (fhead + 1) % 8;
        fcnt--;
        outst--;
        rbeat = 0;
      end else begin
        rbeat++;
      end
    end
    // Request handshake at the coming rise
    if (req_valid && req_ready) begin
      chk(exp_rem == 0, "R9 request taken with beats left", exp_rem, 0);
      exp_addr = int'(req_addr);
      exp_rem  = int'(req_beats);
      exp_size = int'(req_size);
      req_pend = 1;
      want_req = 0;
      accepted = 1;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic send_req(input int a, input int n, input int s);
    want_addr = a;
    want_beats = n;
    want_size = s;
    want_req = 1;
    accepted = 0;
    while (!accepted) tick();
  endtask

  task automatic drain();
    while (exp_rem > 0 || fcnt > 0 || req_pend) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

  initial begin
    int adr;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_beats = '0;
    req_size = '0;
    dn_cmd_ready = 1'b0;
    dn_dat_valid = 1'b0;
    dn_dat_data = '0;
    dn_dat_resp = '0;
    dn_dat_last = 1'b0;
    up_dat_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!dn_cmd_valid, "R11 cmd_valid in reset", int'(dn_cmd_valid), 0);
    chk(!req_ready, "R1 req_ready in reset", int'(req_ready), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(req_ready, "R1 req_ready after reset", int'(req_ready), 1);

    // Sweep: modes x sizes x page offsets x lengths (R2 R3 R4 R5 R7 R8 R9)
    for (int m = 0; m < 2; m++) begin
      mode = m;
      for (int s = 0; s < 3; s++) begin
        for (int k = 0; k < 5; k++) begin
          for (int n = 1; n <= 9; n++) begin
            case (k)
              0: adr = 16'h2000;
              1: adr = 16'h1000 - (1 << s);
              2: adr = 16'h1000 - (2 << s);
              3: adr = 16'h1000 - (3 << s);
              default: adr = 16'h1000 - (5 << s);
            endcase
            send_req(adr, n, s);
          end
        end
      end
      drain();
    end

    // Long request across a page edge with random stalls (R6 R5)
    mode = 1;
    send_req(16'h0FC0, 40, 2);
    send_req(16'h1FF0, 23, 0);
    drain();

    // R11: reset in the middle of a stalled command
    mode = 2;
    send_req(16'h0100, 6, 2);
    tick();
    tick();
    chk(dn_cmd_valid, "R6 command pending before reset", int'(dn_cmd_valid), 1);
    rst_n = 1'b0;
    #1;
    chk(!dn_cmd_valid, "R11 cmd_valid drops at once", int'(dn_cmd_valid), 0);
    chk(!req_ready, "R1 req_ready drops in reset", int'(req_ready), 0);
    exp_rem = 0;
    fcnt = 0;
    fhead = 0;
    ftail = 0;
    outst = 0;
    rbeat = 0;
    prev_stall = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk(req_ready, "R1 req_ready after second reset", int'(req_ready), 1);
    mode = 0;
    send_req(16'h0FF8, 7, 1);
    drain();
    repeat (3) tick();
    report();
  end

endmodule